// File: doc/BRIEF.md
# SDRAM Controller Configuration Register Bank

This block holds the configuration and status state of a four-bank SDRAM controller and performs the live bank decode of incoming bus addresses. Software reaches it through two externally visible registers: an index register (`reg_sel` = 0) and a data window (`reg_sel` = 1). A data-window access goes to the internal register whose address is held in the index register. Writes land on the rising clock edge. Read data is a combinational function of the stored state and `reg_sel`.

The internal registers are as follows:

- Global configuration, with the enable in bit 31.
- A read-only status register whose bits 31 and 30 react to edges of the matching configuration bits.
- Refresh and power-management timing.
- Error-address and error-status registers.
- ECC configuration and ECC error status.
- One configuration register per bank, holding a base address, a power-of-two size code and an enable.

The bank registers also drive an address decoder. This decoder reports whether an address falls in an enabled bank, and which bank that is. An interrupt line stays high for as long as the ECC error status is nonzero.

Top module: `sdram_cfg_regs`

## Requirements
- R1: A write with `reg_sel`=0 loads the 32-bit index register. A read with `reg_sel`=0 returns the index register. With `reg_sel`=1, reads and writes target the internal register whose address equals the index value.
- R2: After reset the following values hold: refresh timing (0x30) = 0x05F00000, power-management timer (0x34) = 0x07C00000, configuration (0x20) = 0x00800000, and timing (0x80) reads 0xFFFFFFFF. Every other register reads 0, including the index register.
- R3: A data write stores the written value ANDed with a per-register mask:
  - configuration (0x20): 0xFFE00000
  - refresh timing (0x30): 0x3FF80000
  - ECC configuration (0x94): 0x00F00000
  - ECC error status (0x98): 0xFFF0F000
  - bank configuration (0x40 + 4·n, n = 0..3): 0xFFDEE001
  - error address (0x10): all 32 bits
- R4: A write to the power-management timer (0x34) stores (value AND 0xF8000000) OR 0x07C00000, so bits 26:22 always read as one.
- R5: The two error status registers (0x00 and 0x08) clear each bit written as one and leave all other bits unchanged. No error source sets them in this block, so they keep reading zero.
- R6: The status register (0x24) ignores data writes. When a configuration write changes bit 31 from 0 to 1, status bit 31 clears. When a configuration write changes bit 31 from 1 to 0, status bit 31 sets.
- R7: When a configuration write changes bit 30 from 0 to 1, status bit 30 sets. When it changes bit 30 from 1 to 0, status bit 30 clears. A write that leaves a bit unchanged leaves the matching status bit alone.
- R8: Reads of the timing register (0x80) return 0xFFFFFFFF. Reads of any index value that is not a listed register address also return 0xFFFFFFFF.
- R9: A bank can produce a hit only while its bit 0 is set and configuration bit 31 is set.
- R10: A bank with size code k = bits 19:17 (k = 0..6, size 4 MiB·2^k) matches when address bits 31:(22+k) equal the same bits of its base. The base is bits 31:23, with base bit 22 taken as zero. Size code 7 never matches. The decode input carries address bits 31:22.
- R11: When several banks match, `dec_bank` gives the lowest-numbered one and `dec_hit` is 1. With no match, both outputs are 0.
- R12: `irq` is 1 exactly while the stored ECC error status is nonzero.
- R13: A write takes effect on the clock edge where `reg_wen` is sampled. Read data, `irq` and the decode outputs reflect the new state from the following cycle. Read data and decode respond combinationally to `reg_sel` and `dec_addr_hi`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 1 | 0 selects the index register, 1 selects the data window |
| reg_wen | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| dec_addr_hi | input | 10 | Bits 31:22 of the bus address to decode |
| dec_hit | output | 1 | Address falls inside an active bank |
| dec_bank | output | 2 | Lowest-numbered matching bank |
| irq | output | 1 | ECC error status is nonzero |

## Verification
Every register result is due one cycle after the edge that samples a write. In that next cycle, `reg_rdata`, `irq` and the decode outputs must already show the new state. Decode and read data follow their select and address inputs in the same cycle, with no added latency. The bench therefore drives each stimulus just after a falling edge and compares all outputs 1 ns later. It then advances its behavioural model on the rising edge that commits the write, so each comparison sees exactly the state the requirements predict for that cycle.

// File: rtl/sdram_cfg_pkg.sv
`timescale 1ns/1ps
package sdram_cfg_pkg;
    localparam int DATA_W    = 32;
    localparam int DEC_LSB   = 22;               // smallest bank is 4 MiB
    localparam int DEC_W     = DATA_W - DEC_LSB; // address bits seen by decode
    localparam int BASE_LSB  = 23;
    localparam int BASE_W    = DATA_W - BASE_LSB;
    localparam int CODE_LSB  = 17;
    localparam int CODE_W    = 3;
    localparam int EN_BIT    = 31;
    localparam int HOLD_BIT  = 30;

    // internal register addresses (index values)
    localparam logic [DATA_W-1:0] IA_ERR0   = 32'h00;
    localparam logic [DATA_W-1:0] IA_ERR1   = 32'h08;
    localparam logic [DATA_W-1:0] IA_EADDR  = 32'h10;
    localparam logic [DATA_W-1:0] IA_CFG    = 32'h20;
    localparam logic [DATA_W-1:0] IA_STAT   = 32'h24;
    localparam logic [DATA_W-1:0] IA_RFSH   = 32'h30;
    localparam logic [DATA_W-1:0] IA_PWR    = 32'h34;
    localparam logic [DATA_W-1:0] IA_BANK0  = 32'h40;
    localparam int                BANK_STEP = 4;
    localparam logic [DATA_W-1:0] IA_TIME   = 32'h80;
    localparam logic [DATA_W-1:0] IA_ECFG   = 32'h94;
    localparam logic [DATA_W-1:0] IA_ESTAT  = 32'h98;

    // write masks and fixed fields
    localparam logic [DATA_W-1:0] CFG_MASK   = 32'hFFE0_0000;
    localparam logic [DATA_W-1:0] RFSH_MASK  = 32'h3FF8_0000;
    localparam logic [DATA_W-1:0] ECFG_MASK  = 32'h00F0_0000;
    localparam logic [DATA_W-1:0] ESTAT_MASK = 32'hFFF0_F000;
    localparam logic [DATA_W-1:0] BANK_MASK  = 32'hFFDE_E001;
    localparam logic [DATA_W-1:0] PWR_MASK   = 32'hF800_0000;
    localparam logic [DATA_W-1:0] PWR_ONES   = 32'h07C0_0000;
    localparam logic [DATA_W-1:0] ALL_ONES   = '1;

    // reset values
    localparam logic [DATA_W-1:0] CFG_RST   = 32'h0080_0000;
    localparam logic [DATA_W-1:0] RFSH_RST  = 32'h05F0_0000;
    localparam logic [DATA_W-1:0] PWR_RST   = 32'h07C0_0000;

    typedef struct packed {
        logic [DATA_W-1:0] idx;
        logic [DATA_W-1:0] err0;
        logic [DATA_W-1:0] err1;
        logic [DATA_W-1:0] eaddr;
        logic [DATA_W-1:0] cfg;
        logic [DATA_W-1:0] stat;
        logic [DATA_W-1:0] rfsh;
        logic [DATA_W-1:0] pwr;
        logic [DATA_W-1:0] ecfg;
        logic [DATA_W-1:0] estat;
    } regs_t;
endpackage

// File: rtl/sdram_cfg_file.sv
`timescale 1ns/1ps
module sdram_cfg_file
    import sdram_cfg_pkg::*;
#(
    parameter int NUM_BANKS = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              reg_sel,
    input  logic                              reg_wen,
    input  logic [DATA_W-1:0]                 reg_wdata,
    output regs_t                             regs,
    output logic [NUM_BANKS-1:0][DATA_W-1:0]  bcr
);
    regs_t                             st_d, st_q;
    logic [NUM_BANKS-1:0][DATA_W-1:0]  bcr_d, bcr_q;
    logic [DATA_W-1:0]                 cfg_w;

    always_comb begin
        st_d  = st_q;
        bcr_d = bcr_q;
        cfg_w = reg_wdata & CFG_MASK;
        if (reg_wen && !reg_sel) begin
            st_d.idx = reg_wdata;
        end else if (reg_wen && reg_sel) begin
            case (st_q.idx)
                IA_ERR0:  st_d.err0  = st_q.err0 & ~reg_wdata;
                IA_ERR1:  st_d.err1  = st_q.err1 & ~reg_wdata;
                IA_EADDR: st_d.eaddr = reg_wdata;
                IA_CFG: begin
                    if (!st_q.cfg[EN_BIT] && cfg_w[EN_BIT])
                        st_d.stat[EN_BIT] = 1'b0;
                    else if (st_q.cfg[EN_BIT] && !cfg_w[EN_BIT])
                        st_d.stat[EN_BIT] = 1'b1;
                    if (!st_q.cfg[HOLD_BIT] && cfg_w[HOLD_BIT])
                        st_d.stat[HOLD_BIT] = 1'b1;
                    else if (st_q.cfg[HOLD_BIT] && !cfg_w[HOLD_BIT])
                        st_d.stat[HOLD_BIT] = 1'b0;
                    st_d.cfg = cfg_w;
                end
                IA_RFSH:  st_d.rfsh  = reg_wdata & RFSH_MASK;
                IA_PWR:   st_d.pwr   = (reg_wdata & PWR_MASK) | PWR_ONES;
                IA_ECFG:  st_d.ecfg  = reg_wdata & ECFG_MASK;
                IA_ESTAT: st_d.estat = reg_wdata & ESTAT_MASK;
                default: begin
                    for (int i = 0; i < NUM_BANKS; i++) begin
                        if (st_q.idx == IA_BANK0 + DATA_W'(i * BANK_STEP))
                            bcr_d[i] = reg_wdata & BANK_MASK;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.cfg  <= CFG_RST;
            st_q.rfsh <= RFSH_RST;
            st_q.pwr  <= PWR_RST;
            bcr_q     <= '0;
        end else begin
            st_q  <= st_d;
            bcr_q <= bcr_d;
        end
    end

    assign regs = st_q;
    assign bcr  = bcr_q;
endmodule

// File: rtl/sdram_cfg_rdmux.sv
`timescale 1ns/1ps
module sdram_cfg_rdmux
    import sdram_cfg_pkg::*;
#(
    parameter int NUM_BANKS = 4
) (
    input  logic                              reg_sel,
    input  regs_t                             regs,
    input  logic [NUM_BANKS-1:0][DATA_W-1:0]  bcr,
    output logic [DATA_W-1:0]                 reg_rdata
);
    logic [DATA_W-1:0] win;

    always_comb begin
        case (regs.idx)
            IA_ERR0:  win = regs.err0;
            IA_ERR1:  win = regs.err1;
            IA_EADDR: win = regs.eaddr;
            IA_CFG:   win = regs.cfg;
            IA_STAT:  win = regs.stat;
            IA_RFSH:  win = regs.rfsh;
            IA_PWR:   win = regs.pwr;
            IA_TIME:  win = ALL_ONES;
            IA_ECFG:  win = regs.ecfg;
            IA_ESTAT: win = regs.estat;
            default: begin
                win = ALL_ONES;
                for (int i = 0; i < NUM_BANKS; i++) begin
                    if (regs.idx == IA_BANK0 + DATA_W'(i * BANK_STEP))
                        win = bcr[i];
                end
            end
        endcase
        reg_rdata = reg_sel ? win : regs.idx;
    end
endmodule

// File: rtl/sdram_bank_match.sv
`timescale 1ns/1ps
module sdram_bank_match
    import sdram_cfg_pkg::*;
(
    input  logic [BASE_W-1:0] base,
    input  logic [CODE_W-1:0] code,
    input  logic              active,
    input  logic [DEC_W-1:0]  addr_hi,
    output logic              match
);
    logic [DEC_W-1:0] base_ext;

    always_comb begin
        base_ext = {base, 1'b0};
        match    = active && (code != {CODE_W{1'b1}});
        for (int j = 0; j < DEC_W; j++) begin
            if (j >= int'(code) && addr_hi[j] != base_ext[j])
                match = 1'b0;
        end
    end
endmodule

// File: rtl/sdram_cfg_regs.sv
`timescale 1ns/1ps
module sdram_cfg_regs
    import sdram_cfg_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_sel,
    input  logic              reg_wen,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [DEC_W-1:0]  dec_addr_hi,
    output logic              dec_hit,
    output logic [BANK_W-1:0] dec_bank,
    output logic              irq
);
    regs_t                             regs;
    logic [NUM_BANKS-1:0][DATA_W-1:0]  bcr;
    logic [NUM_BANKS-1:0]              bank_match;

    sdram_cfg_file #(.NUM_BANKS(NUM_BANKS)) u_file (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_sel   (reg_sel),
        .reg_wen   (reg_wen),
        .reg_wdata (reg_wdata),
        .regs      (regs),
        .bcr       (bcr)
    );

    sdram_cfg_rdmux #(.NUM_BANKS(NUM_BANKS)) u_rdmux (
        .reg_sel   (reg_sel),
        .regs      (regs),
        .bcr       (bcr),
        .reg_rdata (reg_rdata)
    );

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        sdram_bank_match u_match (
            .base    (bcr[g][DATA_W-1:BASE_LSB]),
            .code    (bcr[g][CODE_LSB+CODE_W-1:CODE_LSB]),
            .active  (bcr[g][0] && regs.cfg[EN_BIT]),
            .addr_hi (dec_addr_hi),
            .match   (bank_match[g])
        );
    end

    // lowest index wins: scan from the top so lower banks overwrite
    always_comb begin
        dec_hit  = 1'b0;
        dec_bank = '0;
        for (int i = NUM_BANKS - 1; i >= 0; i--) begin
            if (bank_match[i]) begin
                dec_hit  = 1'b1;
                dec_bank = BANK_W'(i);
            end
        end
    end

    assign irq = |regs.estat;
endmodule

// File: rtl/sdram_cfg_checker.sv
`timescale 1ns/1ps
module sdram_cfg_checker
    import sdram_cfg_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              reg_sel,
    input logic              reg_wen,
    input logic [31:0]       reg_wdata,
    input logic [31:0]       reg_rdata,
    input logic              dec_hit,
    input logic              irq,
    input logic [31:0]       idx_q,
    input logic [31:0]       cfg_q,
    input logic [31:0]       stat_q,
    input logic [31:0]       pwr_q
);
    logic data_wr;
    assign data_wr = reg_wen && reg_sel;

    AST_TIME_READS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel && idx_q == IA_TIME) |-> reg_rdata == 32'hFFFF_FFFF); // R8
    AST_DECODE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q[EN_BIT] |-> !dec_hit); // R9
    AST_IRQ_FOLLOWS_ESTAT: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && idx_q == IA_ESTAT) |=> irq == ($past(reg_wdata & ESTAT_MASK) != 0)); // R12
    AST_STATUS_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && idx_q == IA_STAT) |=> $stable(stat_q)); // R6
    AST_ENABLE_RISE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && idx_q == IA_CFG && !cfg_q[EN_BIT] && reg_wdata[EN_BIT]) |=> !stat_q[EN_BIT]); // R6
    AST_HOLD_RISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && idx_q == IA_CFG && !cfg_q[HOLD_BIT] && reg_wdata[HOLD_BIT]) |=> stat_q[HOLD_BIT]); // R7
    AST_PWR_FIXED_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> pwr_q[26:22] == 5'h1F); // R4
endmodule

bind sdram_cfg_regs sdram_cfg_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_sel   (reg_sel),
    .reg_wen   (reg_wen),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .dec_hit   (dec_hit),
    .irq       (irq),
    .idx_q     (regs.idx),
    .cfg_q     (regs.cfg),
    .stat_q    (regs.stat),
    .pwr_q     (regs.pwr)
);

// File: tb/sdram_cfg_regs_tb.sv
`timescale 1ns/1ps
module sdram_cfg_regs_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_sel = 1'b0;
    logic        reg_wen = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [9:0]  dec_addr_hi = '0;
    logic        dec_hit;
    logic [1:0]  dec_bank;
    logic        irq;

    always #2 clk = ~clk;

    sdram_cfg_regs u_dut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wen(reg_wen),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dec_addr_hi(dec_addr_hi),
        .dec_hit(dec_hit), .dec_bank(dec_bank), .irq(irq)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;
    logic [31:0] probe = '0;

    // behavioural reference state
    logic [31:0] m_idx, m_e0, m_e1, m_ea, m_cfg, m_st, m_rf, m_pw, m_ec, m_es;
    logic [31:0] m_bk [4];

    task automatic m_reset();
        m_idx = 0; m_e0 = 0; m_e1 = 0; m_ea = 0; m_st = 0; m_ec = 0; m_es = 0;
        m_cfg = 32'h0080_0000; m_rf = 32'h05F0_0000; m_pw = 32'h07C0_0000;
        for (int i = 0; i < 4; i++) m_bk[i] = 0;
    endtask

    function automatic logic [31:0] m_read(logic [31:0] a);
        case (a)
            32'h00: return m_e0;
            32'h08: return m_e1;
            32'h10: return m_ea;
            32'h20: return m_cfg;
            32'h24: return m_st;
            32'h30: return m_rf;
            32'h34: return m_pw;
            32'h40: return m_bk[0];
            32'h44: return m_bk[1];
            32'h48: return m_bk[2];
            32'h4C: return m_bk[3];
            32'h94: return m_ec;
            32'h98: return m_es;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    task automatic m_write(logic sel, logic [31:0] v);
        logic [31:0] nc;
        if (!sel) begin m_idx = v; return; end
        case (m_idx)
            32'h00: m_e0 = m_e0 & ~v;
            32'h08: m_e1 = m_e1 & ~v;
            32'h10: m_ea = v;
            32'h20: begin
                nc = v & 32'hFFE0_0000;
                if (m_cfg[31] != nc[31]) m_st[31] = m_cfg[31];
                if (m_cfg[30] != nc[30]) m_st[30] = nc[30];
                m_cfg = nc;
            end
            32'h30: m_rf = v & 32'h3FF8_0000;
            32'h34: m_pw = (v & 32'hF800_0000) | 32'h07C0_0000;
            32'h40: m_bk[0] = v & 32'hFFDE_E001;
            32'h44: m_bk[1] = v & 32'hFFDE_E001;
            32'h48: m_bk[2] = v & 32'hFFDE_E001;
            32'h4C: m_bk[3] = v & 32'hFFDE_E001;
            32'h94: m_ec = v & 32'h00F0_0000;
            32'h98: m_es = v & 32'hFFF0_F000;
            default: ;
        endcase
    endtask

    task automatic m_decode(logic [31:0] a, output logic hit, output logic [1:0] bank);
        longint size, base;
        hit = 0; bank = 0;
        for (int i = 0; i < 4; i++) begin
            if (!hit && m_bk[i][0] && m_cfg[31] && m_bk[i][19:17] != 3'd7) begin
                size = longint'(4 * 1024 * 1024) << m_bk[i][19:17];
                base = longint'(m_bk[i] & 32'hFF80_0000);
                if (longint'(a) / size == base / size) begin
                    hit = 1; bank = 2'(i);
                end
            end
        end
    endtask

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(string tag, logic sel, logic wen, logic [31:0] wd);
        logic       eh;
        logic [1:0] eb;
        @(negedge clk);
        reg_sel = sel; reg_wen = wen; reg_wdata = wd;
        dec_addr_hi = probe[31:22];
        #1;
        check(sel ? tag : "R1", reg_rdata, sel ? m_read(m_idx) : m_idx);
        check("R12", 32'(irq), 32'(m_es != 0));
        m_decode({probe[31:22], 22'b0}, eh, eb);
        check("R10", 32'(dec_hit), 32'(eh));
        check("R11", 32'(dec_bank), 32'(eb));
        @(posedge clk);
        if (wen) m_write(sel, wd);
    endtask

    task automatic wr(string tag, logic [31:0] a, logic [31:0] v);
        step(tag, 0, 1, a);
        step(tag, 1, 1, v);
    endtask

    task automatic rd(string tag, logic [31:0] a);
        step(tag, 0, 1, a);
        step(tag, 1, 0, 0);
    endtask

    task automatic look(string tag, logic [31:0] a);
        probe = a;
        step(tag, 0, 0, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        m_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: reset values over the whole map
        begin
            logic [31:0] amap [14] = '{32'h00, 32'h08, 32'h10, 32'h20, 32'h24, 32'h30, 32'h34,
                                       32'h40, 32'h44, 32'h48, 32'h4C, 32'h80, 32'h94, 32'h98};
            for (int i = 0; i < 14; i++) rd("R2", amap[i]);
        end

        // R1: index register read back
        step("R1", 0, 1, 32'h1234_5678);
        step("R1", 0, 0, 0);

        // R8: timing and unmapped indexes
        rd("R8", 32'h80); rd("R8", 32'h0C); rd("R8", 32'h1234); rd("R8", 32'h50);

        // R3: write masks
        wr("R3", 32'h10, 32'hDEAD_BEEF); rd("R3", 32'h10);
        wr("R3", 32'h30, 32'hFFFF_FFFF); rd("R3", 32'h30);
        wr("R3", 32'h94, 32'hFFFF_FFFF); rd("R3", 32'h94);
        for (int i = 0; i < 4; i++) begin
            wr("R3", 32'h40 + 32'(4 * i), 32'hFFFF_FFFF);
            rd("R3", 32'h40 + 32'(4 * i));
        end
        wr("R8", 32'h80, 32'h1234_5678); rd("R8", 32'h80);

        // R4: power-management fixed ones
        wr("R4", 32'h34, 32'h0); rd("R4", 32'h34);
        wr("R4", 32'h34, 32'hFFFF_FFFF); rd("R4", 32'h34);

        // R5: clear-on-one error registers
        wr("R5", 32'h00, 32'hFFFF_FFFF); rd("R5", 32'h00);
        wr("R5", 32'h08, 32'hA5A5_A5A5); rd("R5", 32'h08);

        // R6 and R7: status follows configuration edges
        wr("R6", 32'h24, 32'hFFFF_FFFF); rd("R6", 32'h24);
        wr("R6", 32'h20, 32'hFFFF_FFFF); rd("R6", 32'h24); rd("R3", 32'h20);
        wr("R6", 32'h20, 32'h0);         rd("R6", 32'h24);
        wr("R7", 32'h20, 32'h4000_0000); rd("R7", 32'h24);
        wr("R7", 32'h20, 32'h4000_0000); rd("R7", 32'h24);
        wr("R6", 32'h20, 32'hC000_0000); rd("R6", 32'h24);
        wr("R7", 32'h20, 32'h8000_0000); rd("R7", 32'h24);
        wr("R6", 32'h24, 32'h0);         rd("R6", 32'h24);

        // R9, R10, R11: bank decode
        wr("R10", 32'h40, 32'h0004_0001);   // 16 MiB at 0
        wr("R10", 32'h44, 32'h0100_0001);   // 4 MiB at 16 MiB
        wr("R10", 32'h48, 32'h0006_0001);   // 32 MiB at 0
        wr("R10", 32'h4C, 32'h200E_0001);   // invalid size code
        look("R13", 32'h0000_0000);
        begin
            logic [31:0] pr [10] = '{32'h0000_0000, 32'h00FF_FFFF, 32'h0100_0000, 32'h013F_FFFF,
                                     32'h0140_0000, 32'h01FF_FFFF, 32'h0200_0000, 32'h2000_0000,
                                     32'h0040_0000, 32'hFFC0_0000};
            for (int i = 0; i < 10; i++) look("R10", pr[i]);
        end
        wr("R11", 32'h4C, 32'h008C_0001);   // 256 MiB, base not aligned
        look("R10", 32'h0500_0000);
        look("R11", 32'h0000_0000);
        wr("R9", 32'h40, 32'h0004_0000);    // bank 0 off
        look("R9", 32'h0000_0000);
        wr("R9", 32'h20, 32'h0);            // global off
        look("R9", 32'h0000_0000);
        look("R9", 32'h0500_0000);
        wr("R9", 32'h20, 32'h8000_0000);
        look("R9", 32'h0500_0000);

        // R12: interrupt from ECC error status
        wr("R12", 32'h98, 32'h0000_1000); rd("R12", 32'h98);
        wr("R12", 32'h98, 32'h000F_0FFF); rd("R12", 32'h98);
        wr("R12", 32'h98, 32'hFFFF_FFFF); rd("R12", 32'h98);
        wr("R12", 32'h98, 32'h0);         rd("R12", 32'h98);

        // R2: reset again mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        m_reset();
        @(negedge clk);
        rst_n = 1'b1;
        probe = 0;
        rd("R2", 32'h20); rd("R2", 32'h40); rd("R2", 32'h34);

        repeat (2) @(posedge clk);
        finish_run();
    end
endmodule